// File: doc/BRIEF.md
# Two-Part Resizable Associative Cache

This block is a four-way set-associative read cache whose ways are divided into a fast primary group and a slower secondary group. The split is set by a two-bit configuration input. It can give the primary group one, two, three or all four ways. The secondary group holds the remaining ways. A lookup compares only the primary ways in its first cycle. The secondary ways are compared in a second cycle, and only when the primary group misses. A line found in the secondary group is exchanged with the least recently used primary line, so that blocks in active use gather in the fast group.

The intended use is phase-adaptive sizing. A controller watches the program behaviour over an interval and then reprograms the split. A narrow primary group can run at a higher clock. A wide primary group catches more hits at first-cycle speed. Changing the split only relabels ways, so the cache keeps its contents across the change. The request port accepts one lookup at a time. Misses are sent to the next memory level over a simple held-valid request port, with a one-word line.

Top module: `twopart_cache`

## Requirements
- R1: The response `resp_status` uses these codes: 1 for a primary hit, 2 for a secondary hit, 3 for a miss. A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. A primary hit raises `resp_valid` with the cached word one clock after that edge.
- R2: When the primary ways miss and the secondary group is not empty, the secondary ways are compared in the next cycle. A secondary hit responds two clocks after acceptance and issues no next-level request.
- R3: On a secondary hit, the hit line moves into the least recently used primary way, and the line that was there moves into the vacated secondary way. A repeat access to the moved line is then a primary hit.
- R4: A miss in both groups raises `mem_req_valid` with `mem_req_addr` equal to the request address. Both stay unchanged until `mem_resp_valid`. The fill word is returned with status 3. With a non-empty secondary group, this happens three clocks after acceptance when memory answers at once.
- R5: Configuration code 3 (all four ways primary) has no secondary phase. A primary miss goes straight to the next level, two clocks after acceptance with immediate memory, and status 2 never occurs.
- R6: Replacement is least-recently-used over all four ways of a set. The fill is written into the least recently used primary way. If the overall victim lies in the secondary group, the displaced primary line moves into the victim's way.
- R7: The configuration code equals the number of primary ways minus one, counted from way 0 upward. It is sampled only while the cache is idle. A change during a request has no effect until that request has completed.
- R8: Changing the configuration invalidates no line. A line present before the change still hits afterwards, in whichever group now contains its way.
- R9: `req_ready` drops on the edge that accepts a request and returns high only with the response, so at most one request is in flight.
- R10: After reset all lines are invalid, `req_ready` is high, and `resp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a_ways | input | 2 | Primary way count minus one |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Cache idle, request can be accepted |
| req_addr | input | ADDR_W | Word address of the lookup |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_data | output | DATA_W | Returned word |
| resp_status | output | 2 | 1 primary hit, 2 secondary hit, 3 miss |
| mem_req_valid | output | 1 | Next-level fetch request, held until answered |
| mem_req_addr | output | ADDR_W | Address to fetch |
| mem_resp_valid | input | 1 | Next-level data strobe |
| mem_resp_data | input | DATA_W | Next-level fill word |

## Verification
The bench builds the cache with ADDR_W=10, DATA_W=16 and SET_BITS=2. With only four sets, a short run of tags in set 0 fills every way and forces evictions in a few requests. Those requests then pass through swaps, relabelled ways and every split. Each fill word carries its own address in its low bits, so a stale or misplaced line shows up as a data mismatch. Latencies are measured in whole cycles, so the single-phase path of the all-primary split is told apart from the two-phase path.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int RANK_W = WAY_W;

    // per-set recency ranks, 0 = most recent, WAYS-1 = least recent
    typedef logic [WAYS-1:0][RANK_W-1:0] rank_vec_t;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_AHIT = 2'd1,
        ST_BHIT = 2'd2,
        ST_MISS = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PROBE_A,
        S_PROBE_B,
        S_FILL
    } state_e;

    // a way belongs to the primary group when its index is at most the code
    function automatic logic way_in_a(input int w, input logic [WAY_W-1:0] last_a);
        return WAY_W'(w) <= last_a;
    endfunction

    function automatic rank_vec_t initial_ranks();
        rank_vec_t r;
        for (int w = 0; w < WAYS; w++) r[w] = RANK_W'(w);
        return r;
    endfunction

endpackage

// File: rtl/cache_way_match.sv
module cache_way_match import cache_pkg::*; #(
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]             valids,
    input  logic [TAG_W-1:0]            tag,
    input  logic [WAY_W-1:0]            last_a,
    output logic                        a_hit,
    output logic                        b_hit,
    output logic [WAY_W-1:0]            a_way,
    output logic [WAY_W-1:0]            b_way
);
    logic [WAYS-1:0] match;
    logic [WAYS-1:0] in_a;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valids[w] && (tags[w] == tag);
        assign in_a[w]  = way_in_a(w, last_a);
    end

    always_comb begin
        a_hit = |(match & in_a);
        b_hit = |(match & ~in_a);
        a_way = '0;
        b_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && in_a[w])  a_way = WAY_W'(w);
            if (match[w] && !in_a[w]) b_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_lru_pick.sv
module cache_lru_pick import cache_pkg::*; (
    input  rank_vec_t        ranks,
    input  logic [WAY_W-1:0] last_a,
    output logic [WAY_W-1:0] a_lru,
    output logic [WAY_W-1:0] g_lru
);
    logic [RANK_W-1:0] best_r;

    always_comb begin
        g_lru  = '0;
        a_lru  = '0;
        best_r = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ranks[w] == RANK_W'(WAYS - 1)) g_lru = WAY_W'(w);
            if (way_in_a(w, last_a) && ranks[w] >= best_r) begin
                best_r = ranks[w];
                a_lru  = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cache_rank_update.sv
// Exchanges the ranks of ways tgt and src (they trade contents), then makes
// tgt the most recent. With tgt == src it is a plain touch.
module cache_rank_update import cache_pkg::*; (
    input  rank_vec_t        ranks,
    input  logic [WAY_W-1:0] tgt,
    input  logic [WAY_W-1:0] src,
    output rank_vec_t        nxt
);
    rank_vec_t         swapped;
    logic [RANK_W-1:0] pivot;

    assign pivot = ranks[src];

    for (genvar w = 0; w < WAYS; w++) begin : g_rank
        always_comb begin
            if (tgt == WAY_W'(w))      swapped[w] = ranks[src];
            else if (src == WAY_W'(w)) swapped[w] = ranks[tgt];
            else                       swapped[w] = ranks[w];

            if (tgt == WAY_W'(w))      nxt[w] = '0;
            else if (swapped[w] < pivot) nxt[w] = swapped[w] + RANK_W'(1);
            else                       nxt[w] = swapped[w];
        end
    end
endmodule

// File: rtl/twopart_cache.sv
module twopart_cache import cache_pkg::*; #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int SET_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_a_ways,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic [1:0]        resp_status,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data
);
    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = ADDR_W - SET_BITS;

    // storage
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    logic [WAYS-1:0]   valid_q[SETS];
    rank_vec_t         rank_q [SETS];

    // control
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  cfg_q;
    logic              resp_valid_q;
    status_e           resp_st_q;
    logic [DATA_W-1:0] resp_data_q;

    // current set view
    logic [SET_BITS-1:0]        set_idx;
    logic [TAG_W-1:0]           look_tag;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    rank_vec_t                  set_rank, rank_nxt;

    logic             a_hit, b_hit;
    logic [WAY_W-1:0] a_way, b_way, a_lru, g_lru;

    // update plan
    logic              rank_en, move_en, resp_en;
    logic [WAY_W-1:0]  upd_t, upd_s;
    logic [TAG_W-1:0]  new_tag;
    logic [DATA_W-1:0] new_data, resp_dat;
    status_e           resp_st;

    assign set_idx  = addr_q[SET_BITS-1:0];
    assign look_tag = addr_q[ADDR_W-1:SET_BITS];
    assign set_valid = valid_q[set_idx];
    assign set_rank  = rank_q[set_idx];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[set_idx][w];
    end

    cache_way_match #(.TAG_W(TAG_W)) i_match (
        .tags   (set_tags),
        .valids (set_valid),
        .tag    (look_tag),
        .last_a (cfg_q),
        .a_hit  (a_hit),
        .b_hit  (b_hit),
        .a_way  (a_way),
        .b_way  (b_way)
    );

    cache_lru_pick i_pick (
        .ranks  (set_rank),
        .last_a (cfg_q),
        .a_lru  (a_lru),
        .g_lru  (g_lru)
    );

    cache_rank_update i_rank (
        .ranks (set_rank),
        .tgt   (upd_t),
        .src   (upd_s),
        .nxt   (rank_nxt)
    );

    always_comb begin
        state_d  = state_q;
        upd_t    = a_way;
        upd_s    = a_way;
        rank_en  = 1'b0;
        move_en  = 1'b0;
        new_tag  = look_tag;
        new_data = mem_resp_data;
        resp_en  = 1'b0;
        resp_st  = ST_NONE;
        resp_dat = '0;
        case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_PROBE_A;
            end
            S_PROBE_A: begin
                if (a_hit) begin
                    rank_en  = 1'b1;
                    resp_en  = 1'b1;
                    resp_st  = ST_AHIT;
                    resp_dat = data_q[set_idx][a_way];
                    state_d  = S_IDLE;
                end else if (cfg_q == WAY_W'(WAYS - 1)) begin
                    state_d = S_FILL;
                end else begin
                    state_d = S_PROBE_B;
                end
            end
            S_PROBE_B: begin
                if (b_hit) begin
                    upd_t    = a_lru;
                    upd_s    = b_way;
                    rank_en  = 1'b1;
                    move_en  = 1'b1;
                    new_tag  = set_tags[b_way];
                    new_data = data_q[set_idx][b_way];
                    resp_en  = 1'b1;
                    resp_st  = ST_BHIT;
                    resp_dat = data_q[set_idx][b_way];
                    state_d  = S_IDLE;
                end else begin
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                if (mem_resp_valid) begin
                    if (g_lru <= cfg_q) begin
                        upd_t = g_lru;
                        upd_s = g_lru;
                    end else begin
                        upd_t = a_lru;
                        upd_s = g_lru;
                    end
                    rank_en  = 1'b1;
                    move_en  = 1'b1;
                    new_tag  = look_tag;
                    new_data = mem_resp_data;
                    resp_en  = 1'b1;
                    resp_st  = ST_MISS;
                    resp_dat = mem_resp_data;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            addr_q       <= '0;
            cfg_q        <= WAY_W'(WAYS - 1);
            resp_valid_q <= 1'b0;
            resp_st_q    <= ST_NONE;
            resp_data_q  <= '0;
        end else begin
            state_q      <= state_d;
            resp_valid_q <= resp_en;
            if (state_q == S_IDLE) cfg_q <= cfg_a_ways;
            if (state_q == S_IDLE && req_valid) addr_q <= req_addr;
            if (resp_en) begin
                resp_st_q   <= resp_st;
                resp_data_q <= resp_dat;
            end
        end
    end

    // storage update
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rank_q[s]  <= initial_ranks();
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else begin
            if (rank_en) rank_q[set_idx] <= rank_nxt;
            if (move_en) begin
                if (upd_s != upd_t) begin
                    tag_q[set_idx][upd_s]   <= set_tags[upd_t];
                    data_q[set_idx][upd_s]  <= data_q[set_idx][upd_t];
                    valid_q[set_idx][upd_s] <= set_valid[upd_t];
                end
                tag_q[set_idx][upd_t]   <= new_tag;
                data_q[set_idx][upd_t]  <= new_data;
                valid_q[set_idx][upd_t] <= 1'b1;
            end
        end
    end

    assign req_ready     = (state_q == S_IDLE);
    assign resp_valid    = resp_valid_q;
    assign resp_data     = resp_data_q;
    assign resp_status   = resp_st_q;
    assign mem_req_valid = (state_q == S_FILL);
    assign mem_req_addr  = addr_q;
endmodule

// File: rtl/twopart_cache_chk.sv
module twopart_cache_chk import cache_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_status,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_resp_valid,
    input logic [WAY_W-1:0]  cfg_q
);
    // R1: a response one cycle after acceptance can only be a primary hit
    p_ahit_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!resp_valid || resp_status == ST_AHIT));

    // R1: every response carries a real status code
    p_status_code_r1: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_status != ST_NONE);

    // R2: a secondary hit never goes through the next level
    p_bhit_local_r2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status == ST_BHIT) |-> !$past(mem_req_valid));

    // R4: fetch request holds its address until answered
    p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: a miss response follows the next-level data strobe
    p_miss_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status == ST_MISS) |-> $past(mem_resp_valid));

    // R5: the all-primary split never reports a secondary hit
    p_no_bhit_full_r5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && cfg_q == WAY_W'(WAYS - 1)) |-> resp_status != ST_BHIT);

    // R7: the active split stays fixed while a request is in flight
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(cfg_q));

    // R9: acceptance closes the request port
    p_one_flight_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9: the port reopens together with the response
    p_resp_idle_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);
endmodule

bind twopart_cache twopart_cache_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_status    (resp_status),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_resp_valid (mem_resp_valid),
    .cfg_q          (cfg_q)
);

// File: tb/test_twopart_cache.sv
module test_twopart_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NVEC = 20;

    localparam logic [1:0] AHIT = 2'd1, BHIT = 2'd2, MISS = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_a_ways = 2'd3;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          resp_valid;
    logic [DW-1:0] resp_data;
    logic [1:0]    resp_status;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_resp_valid = 1'b0;
    logic [DW-1:0] mem_resp_data = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twopart_cache #(.ADDR_W(AW), .DATA_W(DW), .SET_BITS(2)) i_twopart_cache (
        .clk(clk), .rst(rst), .cfg_a_ways(cfg_a_ways),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_status(resp_status),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    // vector: cfg(2) addr(10) status(2) latency(2) requirement(4)
    // tag k in set 0 lives at address 4*k
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd1, 10'd4,  MISS, 2'd3, 4'd4},  // R4 first fill
        {2'd1, 10'd8,  MISS, 2'd3, 4'd10}, // R10 lines start invalid
        {2'd1, 10'd12, MISS, 2'd3, 4'd6},  // R6 displaced primary line to victim way
        {2'd1, 10'd4,  BHIT, 2'd2, 4'd2},  // R2 found in secondary group
        {2'd1, 10'd4,  AHIT, 2'd1, 4'd3},  // R3 swapped into primary
        {2'd1, 10'd12, AHIT, 2'd1, 4'd1},  // R1 primary hit
        {2'd1, 10'd8,  BHIT, 2'd2, 4'd3},  // R3 earlier swap pushed it out
        {2'd1, 10'd16, MISS, 2'd3, 4'd6},  // R6
        {2'd1, 10'd20, MISS, 2'd3, 4'd6},  // R6 evicts tag 1
        {2'd1, 10'd4,  MISS, 2'd3, 4'd6},  // R6 tag 1 was the victim
        {2'd0, 10'd4,  BHIT, 2'd2, 4'd8},  // R8 survives resize
        {2'd0, 10'd20, BHIT, 2'd2, 4'd8},  // R8
        {2'd3, 10'd8,  AHIT, 2'd1, 4'd5},  // R5 all ways primary
        {2'd3, 10'd12, MISS, 2'd2, 4'd5},  // R5 direct to next level
        {2'd3, 10'd24, MISS, 2'd2, 4'd6},  // R6 evicts tag 1
        {2'd2, 10'd8,  BHIT, 2'd2, 4'd8},  // R8
        {2'd2, 10'd4,  MISS, 2'd3, 4'd6},  // R6
        {2'd2, 10'd12, BHIT, 2'd2, 4'd3},  // R3
        {2'd2, 10'h21, MISS, 2'd3, 4'd4},  // R4 other set
        {2'd2, 10'h21, AHIT, 2'd1, 4'd1}   // R1
    };

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {6'b101101, a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] cfg, input logic [AW-1:0] addr,
                           input logic [1:0] exp_st, input int exp_lat,
                           input string req, input bit mid_en,
                           input logic [1:0] mid_cfg);
        int  lat = 0;
        bit  done = 0;
        bit  saw_mem = 0;
        @(negedge clk);
        cfg_a_ways = cfg;
        req_addr   = addr;
        req_valid  = 1'b1;
        while (!done && lat < 40) begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (lat == 1) begin
                chk(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
                if (mid_en) cfg_a_ways = mid_cfg;
            end
            if (resp_valid) begin
                done = 1;
            end else if (mem_resp_valid) begin
                mem_resp_valid = 1'b0;
            end else if (mem_req_valid) begin
                saw_mem = 1;
                chk(mem_req_addr == addr, "R4", "fetch address", int'(mem_req_addr), int'(addr));
                mem_resp_valid = 1'b1;
                mem_resp_data  = fdata(mem_req_addr);
            end
        end
        mem_resp_valid = 1'b0;
        chk(done, req, "response arrived", int'(done), 1);
        chk(resp_status == exp_st, req, "status", int'(resp_status), int'(exp_st));
        chk(resp_data == fdata(addr), req, "data", int'(resp_data), int'(fdata(addr)));
        chk(lat - 1 == exp_lat, req, "latency", lat - 1, exp_lat);
        chk(saw_mem == (exp_st == MISS), req, "next-level use", int'(saw_mem),
            int'(exp_st == MISS));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R10", "no response after reset", int'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R10", "no fetch after reset", int'(mem_req_valid), 0);

        for (int i = 0; i < NVEC; i++) begin
            automatic logic [19:0] v = VEC[i];
            run_req(v[19:18], v[17:8], v[7:6], int'(v[5:4]),
                    $sformatf("R%0d", v[3:0]), 1'b0, 2'd0);
        end

        // R7: split changed in mid-request; the miss still takes the direct path
        run_req(2'd3, 10'h22, MISS, 2, "R7", 1'b1, 2'd0);
        // R7: the new split applies to the next request (line sits in way 3)
        run_req(2'd0, 10'h22, BHIT, 2, "R7", 1'b0, 2'd0);

        repeat (2) @(negedge clk);
        chk(resp_valid == 1'b0, "R9", "response is one pulse", int'(resp_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule